// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block decides, for each of a set of differential clock lanes, whether the lane toggles, sits parked at a fixed level, or is released to high impedance. A free-running internal phase register divides the block clock by two. Its value drives the true leg of every running lane, and its inverse drives the complement leg. The block is meant to sit in front of the pad drivers of a clock buffer.

A single asynchronous stop request comes in, and a strap selects its active level. The request is brought into the clock domain and then debounced against the complement clock. Once a stop is accepted, each lane marked stoppable freezes cleanly at an edge where its true leg is high. When the request is released, the lane restarts on a clean edge.

A global drive-mode bit chooses how a lane parks. In one mode the true leg is held high and driven, with the complement leg undriven. In the other mode both legs are low and undriven. A per-lane output enable overrides everything else and releases both legs.

Top module: `clkstop_ctrl`

## Requirements
- R1: `stop_act_high` = 1 makes `stop_req_in` high the stop level, and 0 makes low the stop level. The strap is changed only under reset.
- R2: The request passes through two synchroniser flops before the debounce logic sees it. A lane therefore cannot leave the running state within two clock cycles of a change in the request.
- R3: The debounce logic samples at every complement-leg rising edge. These are the clock edges at which the internal phase is 1. A new level is accepted only when two consecutive samples are equal, for both assertion and release. A request that is held for only one clock cycle has no effect on any lane.
- R4: A lane with `lane_stoppable` = 0 keeps toggling while a stop is accepted.
- R5: A stoppable lane leaves the running state only at a clock edge where its true leg is 1. Its last transition is therefore a rise.
- R6: A parked lane with `park_float` = 0 has `out_t`=1, `drv_t`=1, `out_c`=0, `drv_c`=0.
- R7: A parked lane with `park_float` = 1 has `out_t`=0, `out_c`=0, `drv_t`=0, `drv_c`=0.
- R8: A lane with `lane_oe` = 0 has all four of its outputs at 0, whatever the request or the mode.
- R9: A parked lane resumes only at a clock edge where the phase is 0, so its true leg comes back as 1. No level on a running leg lasts less than one clock cycle.
- R10: After reset every lane runs, with the phase at 0. An enabled lane then shows `out_t`=0, `out_c`=1, and both drive bits at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the output clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req_in | input | 1 | Asynchronous stop request |
| stop_act_high | input | 1 | Polarity strap for the stop request |
| lane_oe | input | N_OUT | Per-lane output enable |
| lane_stoppable | input | N_OUT | Per-lane stop permission |
| park_float | input | 1 | Parked-state drive mode |
| out_t | output | N_OUT | True-leg data |
| out_c | output | N_OUT | Complement-leg data |
| drv_t | output | N_OUT | True-leg driver enable |
| drv_c | output | N_OUT | Complement-leg driver enable |

## Verification
If the accepted-stop state is wrong, stoppable lanes stop toggling, or fail to stop, within one output period of the wrong acceptance. If the debounce sample register is wrong, acceptance happens one strobe early or late, which shows up as a freeze edge two cycles off. If a lane's run flag is wrong, the lane shows the parked pattern in place of the phase on the very next sampled cycle, or shows a short level at restart. The bench compares all four outputs of every lane on every cycle against a behavioural model.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef struct packed {
    logic t;
    logic c;
    logic dt;
    logic dc;
  } legs_t;

  // request as seen internally: 1 means "stop wanted"
  function automatic logic req_level(input logic raw, input logic act_high);
    return act_high ? raw : ~raw;
  endfunction

  // leg values for one lane from its run flag, the phase, enable and mode
  function automatic legs_t lane_legs(input logic run, input logic ph,
                                      input logic oe, input logic pf);
    legs_t l;
    if (!oe) begin
      l = '0;
    end else if (run) begin
      l.t = ph; l.c = ~ph; l.dt = 1'b1; l.dc = 1'b1;
    end else begin
      l.t = ~pf; l.c = 1'b0; l.dt = ~pf; l.dc = 1'b0;
    end
    return l;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkstop_debounce.sv
module clkstop_debounce (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic lvl,
  output logic samp,
  output logic acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp <= 1'b0;
      acc  <= 1'b0;
    end else if (strobe) begin
      samp <= lvl;
      if (lvl == samp) acc <= lvl;
    end
  end
endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane
  import clkstop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ph,
  input  logic stop_acc,
  input  logic stoppable,
  input  logic oe,
  input  logic park_float,
  output logic run,
  output logic t,
  output logic c,
  output logic dt,
  output logic dc
);
  logic  halt;
  legs_t legs;

  assign halt = stop_acc & stoppable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run <= 1'b1;
    else if (run && halt && ph)  run <= 1'b0;   // freeze with true leg high
    else if (!run && !halt && !ph) run <= 1'b1; // resume as phase rises
  end

  assign legs = lane_legs(run, ph, oe, park_float);
  assign t  = legs.t;
  assign c  = legs.c;
  assign dt = legs.dt;
  assign dc = legs.dc;
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req_in,
  input  logic             stop_act_high,
  input  logic [N_OUT-1:0] lane_oe,
  input  logic [N_OUT-1:0] lane_stoppable,
  input  logic             park_float,
  output logic [N_OUT-1:0] out_t,
  output logic [N_OUT-1:0] out_c,
  output logic [N_OUT-1:0] drv_t,
  output logic [N_OUT-1:0] drv_c
);
  logic             ph_q;
  logic             req_lvl;
  logic             sync_lvl;
  logic             cmp_strobe;
  logic             samp_q;
  logic             acc_q;
  logic [N_OUT-1:0] run_q;

  assign req_lvl = req_level(stop_req_in, stop_act_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  // complement leg rises at the edge where the phase leaves 1
  assign cmp_strobe = ph_q;

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(req_lvl), .q(sync_lvl)
  );

  clkstop_debounce u_deb (
    .clk(clk), .rst_n(rst_n), .strobe(cmp_strobe), .lvl(sync_lvl),
    .samp(samp_q), .acc(acc_q)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    clkstop_lane u_lane (
      .clk(clk), .rst_n(rst_n), .ph(ph_q), .stop_acc(acc_q),
      .stoppable(lane_stoppable[i]), .oe(lane_oe[i]), .park_float(park_float),
      .run(run_q[i]), .t(out_t[i]), .c(out_c[i]), .dt(drv_t[i]), .dc(drv_c[i])
    );
  end
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] lane_oe,
  input logic [N_OUT-1:0] lane_stoppable,
  input logic             park_float,
  input logic [N_OUT-1:0] out_t,
  input logic [N_OUT-1:0] out_c,
  input logic [N_OUT-1:0] drv_t,
  input logic [N_OUT-1:0] drv_c,
  input logic [N_OUT-1:0] run_q,
  input logic             ph_q,
  input logic             cmp_strobe,
  input logic             sync_lvl,
  input logic             samp_q,
  input logic             acc_q
);
  // R3
  accept_two_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q != $past(acc_q)) |-> ($past(cmp_strobe) && ($past(sync_lvl) == $past(samp_q))));

  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    // R8
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_oe[i] |-> (!out_t[i] && !out_c[i] && !drv_t[i] && !drv_c[i]));
    // R5
    freeze_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q[i]) |-> $past(ph_q));
    // R9
    resume_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q[i]) |-> !$past(ph_q));
    // R4
    keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_q[i]) && !$past(lane_stoppable[i])) |-> run_q[i]);
    // R6
    park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[i] && lane_oe[i] && !park_float) |-> (out_t[i] && drv_t[i] && !drv_c[i] && !out_c[i]));
    // R7
    park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[i] && park_float) |-> (!out_t[i] && !drv_t[i] && !drv_c[i] && !out_c[i]));
  end
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lane_oe(lane_oe), .lane_stoppable(lane_stoppable),
  .park_float(park_float), .out_t(out_t), .out_c(out_c), .drv_t(drv_t),
  .drv_c(drv_c), .run_q(run_q), .ph_q(ph_q), .cmp_strobe(cmp_strobe),
  .sync_lvl(sync_lvl), .samp_q(samp_q), .acc_q(acc_q)
);

// File: tb/clkstop_ctrl_test.sv
module clkstop_ctrl_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         stop_req_in;
  logic         stop_act_high;
  logic [N-1:0] lane_oe;
  logic [N-1:0] lane_stoppable;
  logic         park_float;
  logic [N-1:0] out_t, out_c, drv_t, drv_c;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  clkstop_ctrl #(.N_OUT(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .stop_req_in(stop_req_in),
    .stop_act_high(stop_act_high), .lane_oe(lane_oe),
    .lane_stoppable(lane_stoppable), .park_float(park_float),
    .out_t(out_t), .out_c(out_c), .drv_t(drv_t), .drv_c(drv_c)
  );

  // behavioural model, written from the requirements
  logic         m_ph, m_s1, m_s2, m_samp, m_acc;
  logic [N-1:0] m_run, m_run_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_s1 <= 0; m_s2 <= 0; m_samp <= 0; m_acc <= 0;   // R10
      m_run <= '1; m_run_d <= '1;
    end else begin
      m_s1 <= (stop_act_high ? stop_req_in : !stop_req_in);       // R1 R2
      m_s2 <= m_s1;
      if (m_ph) begin                                             // R3
        m_samp <= m_s2;
        if (m_s2 == m_samp) m_acc <= m_s2;
      end
      m_ph <= !m_ph;
      m_run_d <= m_run;
      for (int i = 0; i < N; i++) begin
        if (m_run[i] && m_acc && lane_stoppable[i] && m_ph) m_run[i] <= 0;       // R5
        else if (!m_run[i] && !(m_acc && lane_stoppable[i]) && !m_ph) m_run[i] <= 1; // R9
      end
    end
  end

  function automatic logic [3:0] expect_legs(logic run, logic ph, logic oe, logic pf);
    if (!oe) return 4'b0000;                       // R8
    if (run) return {ph, !ph, 1'b1, 1'b1};         // R4
    if (!pf) return 4'b1010;                       // R6
    return 4'b0000;                                // R7
  endfunction

  function automatic string tag_of(int i);
    if (!lane_oe[i]) return "R8";
    if (m_run[i] && !m_run_d[i]) return "R9";
    if (!m_run[i] && m_run_d[i]) return "R5";
    if (m_run[i]) return "R4";
    return park_float ? "R7" : "R6";
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      for (int i = 0; i < N; i++)
        check(tag_of(i), {out_t[i], out_c[i], drv_t[i], drv_c[i]},
              expect_legs(m_run[i], m_ph, lane_oe[i], park_float));
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic do_reset(input logic pol);
    rst_n = 0; stop_act_high = pol; stop_req_in = !pol;
    lane_oe = '1; lane_stoppable = 4'b0101; park_float = 0;
    step(3);
    rst_n = 1;
    @(negedge clk);
    // R10: lanes run, phase 0 right after reset
    check("R10", {out_t[0], out_c[0], drv_t[0], drv_c[0]}, 4'b0111);
    step(1);
  endtask

  task automatic rand_phase(input int cycles, input logic pol);
    int hold;
    int left = cycles;
    while (left > 0) begin
      hold = 1 + ($urandom % 14);
      stop_req_in = $urandom % 2;
      if (($urandom % 8) == 0) lane_oe = $urandom;
      if (($urandom % 6) == 0) lane_stoppable = $urandom;
      if (($urandom % 10) == 0) park_float = $urandom;
      step(hold);
      left -= hold;
    end
    stop_req_in = !pol;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset(1'b1);

    // R3: one-cycle glitch must not stop anything
    for (int g = 0; g < 4; g++) begin
      stop_req_in = 1; step(1); stop_req_in = 0; step(7);
      @(negedge clk);
      check("R3", {3'b0, out_t[0] ^ out_t[0] ^ (out_c[0] == !out_t[0])}, 4'b0001);
      step(1);
    end

    // R2 R5 R6: held stop, lane 0 stoppable, lane 1 not
    stop_req_in = 1; step(1);
    @(negedge clk);
    check("R2", {3'b0, drv_c[0]}, 4'b0001); // still running right after the request
    step(12);
    @(negedge clk);
    check("R6", {out_t[0], out_c[0], drv_t[0], drv_c[0]}, 4'b1010);
    check("R4", {3'b0, out_t[1]}, {3'b0, m_ph});
    park_float = 1; step(1);
    @(negedge clk);
    check("R7", {out_t[0], out_c[0], drv_t[0], drv_c[0]}, 4'b0000);
    lane_oe[0] = 0; step(1);
    @(negedge clk);
    check("R8", {out_t[0], out_c[0], drv_t[0], drv_c[0]}, 4'b0000);
    lane_oe[0] = 1; park_float = 0;
    stop_req_in = 0; step(12);       // R9: resumes after release
    @(negedge clk);
    check("R9", {3'b0, drv_c[0]}, 4'b0001);
    step(1);

    rand_phase(40000, 1'b1);

    // R1: active-low strap
    do_reset(1'b0);
    stop_req_in = 0; step(14);
    @(negedge clk);
    check("R1", {out_t[0], out_c[0], drv_t[0], drv_c[0]}, 4'b1010);
    step(1);
    stop_req_in = 1; step(14);
    rand_phase(40000, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule